// File: doc/BRIEF.md
# Synthesizer Reference Divider and Lock/Test Output Selector

This block sits between a crystal-rate master clock and the two phase-locked loops of a dual-conversion receiver. It divides the master clock into the two phase-comparison references. It also holds the fixed feedback divider of the second loop, which counts VCO cycles that arrive as single-cycle tick pulses. A 7-bit test code, loaded through a simple write strobe, retunes that feedback divider to one of two test ratios. The same code also chooses what appears on the single test/lock output.

The test output can carry either lock flag, the AND of both flags, or an observation copy of one of four divider nodes. The first-loop programmable divider output is scaled by 16. The first reference is scaled by 8. The second-loop feedback divider is scaled by 2. The second reference appears unscaled. The scaled copies are made by toggle stages, so each is a square wave with a 50 % duty cycle. The final selection goes through a register, so a mode change can never produce a runt pulse on the pin. The lock detectors, phase detectors and VCOs live elsewhere. Lock flags and divider events enter this block as single-clock-domain inputs.

Top module: `refdiv_lockmux`

## Requirements
- R1: `ref1_pulse` is high for exactly one clock cycle, once every 4 master clock cycles.
- R2: `ref2_pulse` is high for exactly one clock cycle, once every 130 master clock cycles.
- R3: With the nominal ratio in force, `fb2_pulse` is a one-cycle pulse issued once per 1034 cycles on which `vco2_tick` is high.
- R4: Test code 0x40 sets the feedback ratio to 987, code 0x60 sets it to 1081, and every other code sets it to 1034. A new ratio first applies to the period that starts after the next `fb2_pulse`, so the period in progress completes with the old ratio.
- R5: While `rst_n` is low, all outputs are 0. After reset the test code is 0x00, so `test_out` follows `rf_lock`.
- R6: Codes 0x00, 0x01 and 0x02 route `rf_lock`, `if_lock`, or the AND of the two to `test_out`. The flag change appears on `test_out` one clock edge after it is applied.
- R7: Code 0x03 makes `test_out` toggle after every 8th `fb1_pulse`, which gives a square wave at 1/16 of the pulse rate. Each change appears two edges after the pulse that causes it.
- R8: Code 0x04 makes `test_out` toggle on every 4th `ref1_pulse`, so its edges are 16 master clock cycles apart.
- R9: Code 0x05 makes `test_out` toggle on every `fb2_pulse`. The edge appears two clock edges after the cycle in which `fb2_pulse` is high.
- R10: Code 0x06 outputs `ref2_pulse` on `test_out` delayed by one clock: high for one cycle, once every 130 cycles.
- R11: Every code not named in R6 to R10 routes `rf_lock` to `test_out`. This covers 0x07 to 0x7F, and includes 0x40 and 0x60.
- R12: A code applied together with `cfg_wr` is loaded at the next clock edge. `test_out` keeps the old mode for that edge and shows the new mode from the following edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock at crystal rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Load strobe for the test code |
| cfg_code | input | 7 | Test code value |
| rf_lock | input | 1 | First loop lock flag |
| if_lock | input | 1 | Second loop lock flag |
| fb1_pulse | input | 1 | One-cycle event from the first loop programmable divider |
| vco2_tick | input | 1 | One-cycle event per second-loop VCO cycle |
| ref1_pulse | output | 1 | First comparison reference pulse |
| ref2_pulse | output | 1 | Second comparison reference pulse |
| fb2_pulse | output | 1 | Second loop feedback divider terminal pulse |
| test_out | output | 1 | Registered lock/test observation output |

## Verification
The latencies are as follows. Lock-flag routing in R6 and R11 is due one edge after the input changes. A mode change is due two edges after the write cycle (R12). A scaled observation edge is due two edges after the event that completes its count (R7, R9). The reference-2 observation copy in R10 is due one edge after `ref2_pulse`.

The driver records each stimulus cycle and queues the expected `test_out` value for exactly that cycle plus the latency. It also queues the unchanged old value one cycle earlier where R12 applies. The monitor compares at the falling clock edge of the due cycle and flags any expected item whose cycle has already passed. Divider periods (R1 to R4, R8) are measured as exact cycle distances between successive pulses or edges. The ratio-change check expects the old period and then the new one, in that order.

// File: rtl/rdiv_pkg.sv
`timescale 1ns/1ps
package rdiv_pkg;

   localparam int CODE_W = 7;
   localparam int NSEL   = 7;

   // selector index order is the order of the source vector in the top
   typedef enum logic [2:0] {
      SEL_RF   = 3'd0,
      SEL_IF   = 3'd1,
      SEL_BOTH = 3'd2,
      SEL_FB1  = 3'd3,
      SEL_REF1 = 3'd4,
      SEL_FB2  = 3'd5,
      SEL_REF2 = 3'd6
   } tsel_e;

   typedef enum logic [1:0] {
      RAT_NOM = 2'd0,
      RAT_LO  = 2'd1,
      RAT_HI  = 2'd2
   } rat_e;

   localparam logic [CODE_W-1:0] CODE_LAST_SEL = 7'h06;
   localparam logic [CODE_W-1:0] CODE_RAT_LO   = 7'h40;
   localparam logic [CODE_W-1:0] CODE_RAT_HI   = 7'h60;

   function automatic tsel_e code_to_sel(input logic [CODE_W-1:0] code);
      tsel_e s;
      if (code <= CODE_LAST_SEL) s = tsel_e'(code[2:0]);
      else                       s = SEL_RF;
      return s;
   endfunction

   function automatic rat_e code_to_rat(input logic [CODE_W-1:0] code);
      rat_e r;
      if (code == CODE_RAT_LO)      r = RAT_LO;
      else if (code == CODE_RAT_HI) r = RAT_HI;
      else                          r = RAT_NOM;
      return r;
   endfunction

endpackage

// File: rtl/rdiv_fixed.sv
`timescale 1ns/1ps
module rdiv_fixed #(
   parameter int RATIO = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic term
);
   localparam int CW = (RATIO > 1) ? $clog2(RATIO) : 1;
   localparam logic [CW-1:0] LAST = CW'(RATIO - 1);

   generate
      if (RATIO < 2) begin : g_bad_ratio
         $error("rdiv_fixed: RATIO must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt_q;
   logic          wrap;

   assign wrap = en && (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         term  <= 1'b0;
      end else begin
         term <= wrap;
         if (en) cnt_q <= wrap ? '0 : cnt_q + 1'b1;
      end
   end

   // R1 R2
   term_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      term |=> !term);

endmodule

// File: rtl/rdiv_fb.sv
`timescale 1ns/1ps
module rdiv_fb
   import rdiv_pkg::*;
#(
   parameter int NOM = 1034,
   parameter int LO  = 987,
   parameter int HI  = 1081
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  rat_e rat_req,
   output logic pulse
);
   localparam int MAX_A = (NOM > LO) ? NOM : LO;
   localparam int MAXR  = (MAX_A > HI) ? MAX_A : HI;
   localparam int RW    = $clog2(MAXR + 1);
   localparam logic [RW-1:0] R_NOM = RW'(NOM);
   localparam logic [RW-1:0] R_LO  = RW'(LO);
   localparam logic [RW-1:0] R_HI  = RW'(HI);

   generate
      if (NOM < 2 || LO < 2 || HI < 2) begin : g_bad_ratio
         $error("rdiv_fb: every ratio must be at least 2");
      end
   endgenerate

   logic [RW-1:0] ratio_q;
   logic [RW-1:0] ratio_next;
   logic [RW-1:0] cnt_q;
   logic          wrap;

   always_comb begin
      case (rat_req)
         RAT_LO:  ratio_next = R_LO;
         RAT_HI:  ratio_next = R_HI;
         default: ratio_next = R_NOM;
      endcase
   end

   assign wrap = tick && (cnt_q == ratio_q - 1'b1);

   // the active ratio is only replaced at a terminal count
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         ratio_q <= R_NOM;
         pulse   <= 1'b0;
      end else begin
         pulse <= wrap;
         if (wrap) begin
            cnt_q   <= '0;
            ratio_q <= ratio_next;
         end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   // R3
   cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < ratio_q);

   // R4
   ratio_at_term_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ratio_q) |-> pulse);

endmodule

// File: rtl/rdiv_scale.sv
`timescale 1ns/1ps
module rdiv_scale #(
   parameter int DIV = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ev,
   output logic q
);
   generate
      if (DIV == 2) begin : g_tff
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  q <= 1'b0;
            else if (ev) q <= ~q;
         end
      end else if (DIV > 2 && (DIV & (DIV - 1)) == 0) begin : g_cnt_tff
         localparam int HALF = DIV / 2;
         localparam int CW   = $clog2(HALF);
         localparam logic [CW-1:0] LAST = CW'(HALF - 1);
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
               q     <= 1'b0;
            end else if (ev) begin
               if (cnt_q == LAST) begin
                  cnt_q <= '0;
                  q     <= ~q;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
         end
      end else begin : g_bad_div
         $error("rdiv_scale: DIV must be a power of two of at least 2");
      end
   endgenerate

   // R7 R8 R9
   toggle_on_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(q) |-> $past(ev));

endmodule

// File: rtl/rdiv_testmux.sv
`timescale 1ns/1ps
module rdiv_testmux
   import rdiv_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  tsel_e           sel,
   input  logic [NSEL-1:0] src,
   output logic            out_q
);
   logic [NSEL-1:0] hit;

   // AND-OR selection, then one register so the pin never sees a runt
   generate
      for (genvar i = 0; i < NSEL; i++) begin : g_leg
         assign hit[i] = src[i] && (int'(sel) == i);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_q <= 1'b0;
      else        out_q <= |hit;
   end

endmodule

// File: rtl/refdiv_lockmux.sv
`timescale 1ns/1ps
module refdiv_lockmux
   import rdiv_pkg::*;
#(
   parameter int REF1_DIV     = 4,
   parameter int REF2_DIV     = 130,
   parameter int FB_NOM       = 1034,
   parameter int FB_TEST_LO   = 987,
   parameter int FB_TEST_HI   = 1081,
   parameter int FB1_OBS_DIV  = 16,
   parameter int REF1_OBS_DIV = 8,
   parameter int FB2_OBS_DIV  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [CODE_W-1:0] cfg_code,
   input  logic              rf_lock,
   input  logic              if_lock,
   input  logic              fb1_pulse,
   input  logic              vco2_tick,
   output logic              ref1_pulse,
   output logic              ref2_pulse,
   output logic              fb2_pulse,
   output logic              test_out
);
   logic [CODE_W-1:0] code_q;
   tsel_e             sel_w;
   rat_e              rat_w;
   logic              fb1_obs;
   logic              ref1_obs;
   logic              fb2_obs;
   logic [NSEL-1:0]   src_w;

   // R12 test code register, R5 reset value selects the first-loop lock flag
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      code_q <= '0;
      else if (cfg_wr) code_q <= cfg_code;
   end

   assign sel_w = code_to_sel(code_q);
   assign rat_w = code_to_rat(code_q);

   rdiv_fixed #(.RATIO(REF1_DIV)) u_ref1 (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (1'b1),
      .term (ref1_pulse)
   );

   rdiv_fixed #(.RATIO(REF2_DIV)) u_ref2 (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (1'b1),
      .term (ref2_pulse)
   );

   rdiv_fb #(.NOM(FB_NOM), .LO(FB_TEST_LO), .HI(FB_TEST_HI)) u_fb2 (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (vco2_tick),
      .rat_req(rat_w),
      .pulse  (fb2_pulse)
   );

   rdiv_scale #(.DIV(FB1_OBS_DIV)) u_obs_fb1 (
      .clk  (clk),
      .rst_n(rst_n),
      .ev   (fb1_pulse),
      .q    (fb1_obs)
   );

   rdiv_scale #(.DIV(REF1_OBS_DIV)) u_obs_ref1 (
      .clk  (clk),
      .rst_n(rst_n),
      .ev   (ref1_pulse),
      .q    (ref1_obs)
   );

   rdiv_scale #(.DIV(FB2_OBS_DIV)) u_obs_fb2 (
      .clk  (clk),
      .rst_n(rst_n),
      .ev   (fb2_pulse),
      .q    (fb2_obs)
   );

   // source order matches the tsel_e encoding
   assign src_w = {ref2_pulse, fb2_obs, ref1_obs, fb1_obs,
                   rf_lock & if_lock, if_lock, rf_lock};

   rdiv_testmux u_mux (
      .clk  (clk),
      .rst_n(rst_n),
      .sel  (sel_w),
      .src  (src_w),
      .out_q(test_out)
   );

   // R6 R11
   rf_lock_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(sel_w) == SEL_RF) |-> (test_out == $past(rf_lock)));

   // R6
   both_lock_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(sel_w) == SEL_BOTH)
         |-> (test_out == ($past(rf_lock) && $past(if_lock))));

   // R10
   ref2_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(sel_w) == SEL_REF2) |-> (test_out == $past(ref2_pulse)));

endmodule

// File: tb/test_refdiv_lockmux.sv
`timescale 1ns/1ps
module test_refdiv_lockmux;

   logic       clk       = 1'b0;
   logic       rst_n     = 1'b0;
   logic       cfg_wr    = 1'b0;
   logic [6:0] cfg_code  = 7'h00;
   logic       rf_lock   = 1'b0;
   logic       if_lock   = 1'b0;
   logic       fb1_pulse = 1'b0;
   logic       vco2_tick = 1'b0;
   logic       ref1_pulse;
   logic       ref2_pulse;
   logic       fb2_pulse;
   logic       test_out;

   int cyc   = 0;
   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   typedef struct {
      int    at;
      logic  val;
      string tag;
   } exp_t;
   exp_t exp_q[$];

   refdiv_lockmux i_refdiv_lockmux (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_wr    (cfg_wr),
      .cfg_code  (cfg_code),
      .rf_lock   (rf_lock),
      .if_lock   (if_lock),
      .fb1_pulse (fb1_pulse),
      .vco2_tick (vco2_tick),
      .ref1_pulse(ref1_pulse),
      .ref2_pulse(ref2_pulse),
      .fb2_pulse (fb2_pulse),
      .test_out  (test_out)
   );

   always #2.5 clk = ~clk;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string tag, input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d, expected %0d (cycle %0d)", tag, act, expv, cyc);
      end
   endtask

   task automatic expect_at(input int at, input logic v, input string tag);
      exp_t e;
      e.at  = at;
      e.val = v;
      e.tag = tag;
      exp_q.push_back(e);
   endtask

   // monitor: pops queued expectations when their cycle is due
   always @(negedge clk) begin
      while (exp_q.size() > 0 && exp_q[0].at <= cyc) begin
         exp_t e;
         e = exp_q.pop_front();
         if (e.at == cyc) check(test_out === e.val, e.tag, int'(test_out), int'(e.val));
         else             check(1'b0, {e.tag, " (missed)"}, -1, int'(e.val));
      end
   end

   function automatic logic pick(input int w);
      case (w)
         0:       return ref1_pulse;
         1:       return ref2_pulse;
         2:       return fb2_pulse;
         default: return test_out;
      endcase
   endfunction

   task automatic wait_high(input int w, output int at);
      do @(negedge clk); while (pick(w) !== 1'b1);
      at = cyc;
   endtask

   task automatic wait_edge(output int at);
      logic p;
      p = test_out;
      do @(negedge clk); while (test_out === p);
      at = cyc;
   endtask

   task automatic write_code(input logic [6:0] c, output int at);
      @(negedge clk);
      cfg_code = c;
      cfg_wr   = 1'b1;
      at       = cyc;
      @(negedge clk);
      cfg_wr   = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog (R1..R12 run): actual timeout, expected completion");
         finish_run();
      end
   end

   initial begin : main
      int w, c, a0, a1, a2, q0, q1, q2;

      // R5: outputs low while reset is held
      repeat (4) @(negedge clk);
      check(test_out === 1'b0, "R5 test_out in reset", int'(test_out), 0);
      check(ref1_pulse === 1'b0 && ref2_pulse === 1'b0 && fb2_pulse === 1'b0,
            "R5 pulses in reset", int'(ref1_pulse | ref2_pulse | fb2_pulse), 0);
      rst_n = 1'b1;

      // R5: reset code routes rf_lock
      repeat (2) @(negedge clk);
      rf_lock = 1'b1; c = cyc;
      expect_at(c + 1, 1'b1, "R5 reset mode follows rf_lock high");
      repeat (2) @(negedge clk);
      rf_lock = 1'b0; c = cyc;
      expect_at(c + 1, 1'b0, "R5 reset mode follows rf_lock low");
      repeat (2) @(negedge clk);

      // R12 and R6: switch to IF lock with rf=1, if=0
      rf_lock = 1'b1; if_lock = 1'b0;
      repeat (2) @(negedge clk);
      write_code(7'h01, w);
      expect_at(w + 1, 1'b1, "R12 old mode held one edge");
      expect_at(w + 2, 1'b0, "R12 new mode from second edge");
      repeat (3) @(negedge clk);
      if_lock = 1'b1; c = cyc;
      expect_at(c + 1, 1'b1, "R6 if_lock routed");
      repeat (2) @(negedge clk);

      // R6: both locked
      write_code(7'h02, w);
      expect_at(w + 2, 1'b1, "R6 both flags high");
      repeat (3) @(negedge clk);
      rf_lock = 1'b0; c = cyc;
      expect_at(c + 1, 1'b0, "R6 rf unlocked gives low");
      repeat (2) @(negedge clk);
      rf_lock = 1'b1; if_lock = 1'b0; c = cyc;
      expect_at(c + 1, 1'b0, "R6 if unlocked gives low");
      repeat (2) @(negedge clk);

      // R11: unlisted codes route rf_lock
      write_code(7'h15, w);
      expect_at(w + 2, 1'b1, "R11 code 0x15 routes rf_lock");
      repeat (3) @(negedge clk);
      rf_lock = 1'b0; c = cyc;
      expect_at(c + 1, 1'b0, "R11 code 0x15 follows rf_lock low");
      repeat (2) @(negedge clk);
      write_code(7'h7F, w);
      repeat (3) @(negedge clk);
      rf_lock = 1'b1; c = cyc;
      expect_at(c + 1, 1'b1, "R11 code 0x7F routes rf_lock");
      repeat (3) @(negedge clk);

      // R1: reference 1 period and width
      wait_high(0, a0);
      @(negedge clk);
      check(ref1_pulse === 1'b0, "R1 ref1 pulse width", int'(ref1_pulse), 0);
      wait_high(0, a1);
      wait_high(0, a2);
      check(a1 - a0 == 4, "R1 ref1 period", a1 - a0, 4);
      check(a2 - a1 == 4, "R1 ref1 period repeat", a2 - a1, 4);

      // R2: reference 2 period and width
      wait_high(1, a0);
      @(negedge clk);
      check(ref2_pulse === 1'b0, "R2 ref2 pulse width", int'(ref2_pulse), 0);
      wait_high(1, a1);
      wait_high(1, a2);
      check(a1 - a0 == 130, "R2 ref2 period", a1 - a0, 130);
      check(a2 - a1 == 130, "R2 ref2 period repeat", a2 - a1, 130);

      // R8: reference 1 divided by 8
      write_code(7'h04, w);
      repeat (4) @(negedge clk);
      wait_edge(a0);
      wait_edge(a1);
      wait_edge(a2);
      check(a1 - a0 == 16, "R8 ref1/8 half period", a1 - a0, 16);
      check(a2 - a1 == 16, "R8 ref1/8 half period repeat", a2 - a1, 16);

      // R10: reference 2 undivided, one clock behind ref2_pulse
      write_code(7'h06, w);
      repeat (4) @(negedge clk);
      wait_high(1, a0);
      expect_at(a0 + 1, 1'b1, "R10 test_out one clock after ref2_pulse");
      expect_at(a0 + 2, 1'b0, "R10 test_out single cycle");
      wait_high(3, a1);
      wait_high(3, a2);
      check(a2 - a1 == 130, "R10 observed ref2 period", a2 - a1, 130);
      repeat (3) @(negedge clk);

      // R7: fb1 divided by 16; no fb1 events occurred before this point
      write_code(7'h03, w);
      expect_at(w + 2, 1'b0, "R7 starts low");
      repeat (3) @(negedge clk);
      for (int k = 1; k <= 17; k++) begin
         @(negedge clk);
         fb1_pulse = 1'b1;
         c = cyc;
         @(negedge clk);
         fb1_pulse = 1'b0;
         expect_at(c + 2, ((k / 8) % 2) == 1, "R7 toggle every 8th fb1 pulse");
      end
      repeat (4) @(negedge clk);

      // R3 and R9: nominal feedback ratio, observation divided by 2
      write_code(7'h05, w);
      @(negedge clk);
      vco2_tick = 1'b1;
      wait_high(2, a0);
      wait_high(2, a1);
      wait_high(2, a2);
      check(a1 - a0 == 1034, "R3 nominal feedback period", a1 - a0, 1034);
      check(a2 - a1 == 1034, "R3 nominal feedback period repeat", a2 - a1, 1034);
      wait_high(2, a0);
      wait_edge(a1);
      check(a1 - a0 == 2, "R9 edge two clocks after fb2_pulse", a1 - a0, 2);
      wait_edge(a2);
      check(a2 - a1 == 1034, "R9 fb2/2 half period", a2 - a1, 1034);

      // R4: ratio changes wait for the terminal count
      wait_high(2, q0);
      write_code(7'h40, w);
      wait_high(2, q1);
      wait_high(2, q2);
      check(q1 - q0 == 1034, "R4 period in progress keeps 1034", q1 - q0, 1034);
      check(q2 - q1 == 987, "R4 code 0x40 ratio 987", q2 - q1, 987);
      write_code(7'h60, w);
      wait_high(2, q1);
      wait_high(2, q0);
      check(q1 - q2 == 987, "R4 period in progress keeps 987", q1 - q2, 987);
      check(q0 - q1 == 1081, "R4 code 0x60 ratio 1081", q0 - q1, 1081);
      write_code(7'h02, w);
      wait_high(2, q1);
      wait_high(2, q2);
      check(q1 - q0 == 1081, "R4 period in progress keeps 1081", q1 - q0, 1081);
      check(q2 - q1 == 1034, "R4 other code returns to 1034", q2 - q1, 1034);

      repeat (5) @(negedge clk);
      check(exp_q.size() == 0, "R12 all queued expectations consumed", exp_q.size(), 0);
      finish_run();
   end

endmodule